// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block holds the program counter of a small accumulator-style controller whose code space is 13 bits wide. Every cycle the decoder presents at most a few one-cycle command strobes: advance, jump, call, return, write of the counter's low byte, and write of the page latch. The block computes the next counter value, keeps return addresses in a private eight-entry circular stack, and tells the fetch stage to throw away its prefetched word whenever the flow of control changes.

Jump and call words carry only an 11-bit target. The two top address bits come from the upper bits of a separately written 5-bit page latch. Software can also write the counter's low byte as if it were a data register. The counter then takes its low 8 bits from the data bus and its top 5 bits from the whole page latch, which gives a computed jump. The return stack lives outside data memory. It has no bottom. When too many calls nest, the oldest entry is lost and a sticky flag is raised.

Top module: `paged_pc_unit`

## Requirements
- R1: After reset the counter is 0, the flush output is 0, the overflow flag is 0, the page latch is 0 and the stack is empty.
- R2: When the advance strobe is the only active command, the counter becomes counter+1 one cycle later, wrapping from 8191 to 0, and the flush output stays 0.
- R3: A jump loads the counter with {latch[4:3], target[10:0]}.
- R4: A low-byte write loads the counter with {latch[4:0], data[7:0]}.
- R5: A latch write stores data[4:0] in the page latch. A jump, call or low-byte write in the same cycle still uses the previous latch value.
- R6: A call pushes the current counter value unchanged, because that value already points past the call. It then loads the counter as a jump does.
- R7: A return loads the counter with the most recently pushed address that has not yet been popped, in last-in first-out order.
- R8: The stack holds 8 entries in a circular array. A ninth outstanding push overwrites the oldest entry and sets the overflow flag. Only reset clears the flag.
- R9: A pop from an empty stack still moves the pointer back one slot and returns the entry found there. It does not set the overflow flag.
- R10: The flush output is 1 in exactly the cycle after a jump, call, return or low-byte write was accepted, and 0 otherwise.
- R11: When several flow commands are active together, only the one with the highest priority acts, in the order return, call, jump, low-byte write, advance. The losing commands change neither the counter nor the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Advance counter by one |
| jmp_i | input | 1 | Unconditional jump |
| call_i | input | 1 | Subroutine call |
| ret_i | input | 1 | Return from subroutine |
| lo_wr_i | input | 1 | Write counter low byte from data bus |
| page_wr_i | input | 1 | Write page latch from data bus |
| data_i | input | 8 | Data bus |
| target_i | input | 11 | Jump or call target field |
| pc_o | output | 13 | Program counter |
| flush_o | output | 1 | Discard prefetched word |
| ovf_o | output | 1 | Sticky stack overflow flag |

## Verification
The bench drives the stack past its depth. A design that counted wrongly would either refuse the ninth push, fail to raise the flag, or keep the oldest entry in place. It also pops an empty stack, where a design that clamped the pointer would return a stale or zero address instead of the wrapped entry. Same-cycle latch and low-byte writes catch a design that forwards the new latch value. Random mixes of simultaneous strobes expose a wrong priority order or a losing call that still pushes. A low-byte write of 0xFF under page 0x1F followed by an advance checks the wrap from the top of the code space to 0.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int PC_W   = 13;
  localparam int LOW_W  = 11;
  localparam int DATA_W = 8;
  localparam int HI_W   = PC_W - DATA_W;
  localparam int DEPTH  = 8;

  typedef logic [PC_W-1:0] pc_t;

  typedef enum logic [2:0] {
    SEL_HOLD = 3'd0,
    SEL_ADV  = 3'd1,
    SEL_JUMP = 3'd2,
    SEL_LOWB = 3'd3,
    SEL_POP  = 3'd4
  } sel_e;

  function automatic pc_t pc_step(input pc_t cur);
    return cur + pc_t'(1);
  endfunction

  function automatic pc_t pc_jump(input logic [HI_W-1:0] page,
                                  input logic [LOW_W-1:0] tgt);
    return {page[HI_W-1 -: PC_W-LOW_W], tgt};
  endfunction

  function automatic pc_t pc_lowb(input logic [HI_W-1:0] page,
                                  input logic [DATA_W-1:0] d);
    return {page, d};
  endfunction
endpackage

// File: rtl/ppc_cmd_sel.sv
module ppc_cmd_sel
  import ppc_pkg::*;
(
  input  logic adv_i,
  input  logic jmp_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic lo_wr_i,
  output sel_e sel_o,
  output logic push_o,
  output logic pop_o
);
  always_comb begin
    sel_o  = SEL_HOLD;
    push_o = 1'b0;
    pop_o  = 1'b0;
    if (ret_i) begin
      sel_o = SEL_POP;
      pop_o = 1'b1;
    end else if (call_i) begin
      sel_o  = SEL_JUMP;
      push_o = 1'b1;
    end else if (jmp_i) begin
      sel_o = SEL_JUMP;
    end else if (lo_wr_i) begin
      sel_o = SEL_LOWB;
    end else if (adv_i) begin
      sel_o = SEL_ADV;
    end
  end
endmodule

// File: rtl/ppc_ret_stack.sv
module ppc_ret_stack
  import ppc_pkg::*;
#(
  parameter int AW    = PC_W,
  parameter int DEPTH_P = DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] top_o,
  output logic          ovf_o
);
  localparam int PW = $clog2(DEPTH_P);
  localparam int FW = PW + 1;

  logic [AW-1:0] mem [DEPTH_P];
  logic [PW-1:0] ptr;
  logic [FW-1:0] fill;
  logic [PW-1:0] ptr_dec;

  assign ptr_dec = ptr - PW'(1);
  assign top_o   = mem[ptr_dec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      fill  <= '0;
      ovf_o <= 1'b0;
    end else if (push_i) begin
      ptr <= ptr + PW'(1);
      if (fill == FW'(DEPTH_P)) ovf_o <= 1'b1;
      else                      fill  <= fill + FW'(1);
    end else if (pop_i) begin
      ptr <= ptr_dec;
      if (fill != '0) fill <= fill - FW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[ptr] <= wdata_i;
  end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import ppc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              jmp_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              lo_wr_i,
  input  logic              page_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LOW_W-1:0]  target_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              flush_o,
  output logic              ovf_o
);
  sel_e            sel;
  logic            push_evt;
  logic            pop_evt;
  logic            redirect_evt;
  logic [HI_W-1:0] page_q;
  pc_t             pc_q;
  pc_t             pc_nxt;
  pc_t             stack_top;

  ppc_cmd_sel u_sel (
    .adv_i   (adv_i),
    .jmp_i   (jmp_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .lo_wr_i (lo_wr_i),
    .sel_o   (sel),
    .push_o  (push_evt),
    .pop_o   (pop_evt)
  );

  ppc_ret_stack #(.AW(PC_W), .DEPTH_P(DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_evt),
    .pop_i   (pop_evt),
    .wdata_i (pc_q),
    .top_o   (stack_top),
    .ovf_o   (ovf_o)
  );

  assign redirect_evt = (sel == SEL_JUMP) || (sel == SEL_LOWB) || (sel == SEL_POP);

  always_comb begin
    unique case (sel)
      SEL_ADV:  pc_nxt = pc_step(pc_q);
      SEL_JUMP: pc_nxt = pc_jump(page_q, target_i);
      SEL_LOWB: pc_nxt = pc_lowb(page_q, data_i);
      SEL_POP:  pc_nxt = stack_top;
      default:  pc_nxt = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      page_q  <= '0;
      flush_o <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      flush_o <= redirect_evt;
      if (page_wr_i) page_q <= data_i[HI_W-1:0];
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker
  import ppc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              adv_i,
  input logic              jmp_i,
  input logic              call_i,
  input logic              ret_i,
  input logic              lo_wr_i,
  input logic [DATA_W-1:0] data_i,
  input logic [LOW_W-1:0]  target_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              flush_o,
  input logic              ovf_o,
  input logic              push_evt,
  input logic              pop_evt
);
  logic flow;
  assign flow = jmp_i | call_i | ret_i | lo_wr_i;

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !flow) |=> (pc_o == $past(pc_o) + PC_W'(1))); // R2
  AST_JUMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((jmp_i || call_i) && !ret_i) |=> (pc_o[LOW_W-1:0] == $past(target_i))); // R3
  AST_LOWB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr_i && !jmp_i && !call_i && !ret_i) |=> (pc_o[DATA_W-1:0] == $past(data_i))); // R4
  AST_FLUSH_ON: assert property (@(posedge clk) disable iff (!rst_n)
    flow |=> flush_o); // R10
  AST_FLUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !flow |=> !flush_o); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o); // R8
  AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({push_evt, pop_evt}) <= 1); // R11
  AST_POP_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !ovf_o) |=> !ovf_o); // R9
endmodule

bind paged_pc_unit ppc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .adv_i    (adv_i),
  .jmp_i    (jmp_i),
  .call_i   (call_i),
  .ret_i    (ret_i),
  .lo_wr_i  (lo_wr_i),
  .data_i   (data_i),
  .target_i (target_i),
  .pc_o     (pc_o),
  .flush_o  (flush_o),
  .ovf_o    (ovf_o),
  .push_evt (push_evt),
  .pop_evt  (pop_evt)
);

// File: tb/test_paged_pc_unit.sv
`timescale 1ns/1ps
module test_paged_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_i = 0, jmp_i = 0, call_i = 0, ret_i = 0, lo_wr_i = 0, page_wr_i = 0;
  logic [7:0]  data_i = '0;
  logic [10:0] target_i = '0;
  logic [12:0] pc_o;
  logic        flush_o, ovf_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // bench reference state
  int unsigned m_pc, m_page, m_sp, m_depth;
  int unsigned m_stk [8];
  bit m_ovf, m_flush;

  always #2 clk = ~clk;

  paged_pc_unit i_paged_pc_unit (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .jmp_i(jmp_i), .call_i(call_i),
    .ret_i(ret_i), .lo_wr_i(lo_wr_i), .page_wr_i(page_wr_i), .data_i(data_i),
    .target_i(target_i), .pc_o(pc_o), .flush_o(flush_o), .ovf_o(ovf_o)
  );

  task automatic check(string req, int unsigned got, int unsigned exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int unsigned jump_addr(int unsigned page, int unsigned tgt);
    return ((page / 8) % 4) * 2048 + (tgt % 2048);
  endfunction

  function automatic int unsigned lowb_addr(int unsigned page, int unsigned d);
    return (page % 32) * 256 + (d % 256);
  endfunction

  // apply one cycle of strobes, update reference, compare after the edge
  task automatic step(bit a, bit j, bit c, bit r, bit l, bit p,
                      int unsigned d, int unsigned t);
    string tag;
    adv_i = a; jmp_i = j; call_i = c; ret_i = r; lo_wr_i = l; page_wr_i = p;
    data_i = d[7:0]; target_i = t[10:0];
    tag = "R2";
    m_flush = 0;
    if (r) begin
      m_sp = (m_sp + 7) % 8;
      m_pc = m_stk[m_sp];
      if (m_depth > 0) m_depth--;
      m_flush = 1; tag = (m_depth == 0) ? "R9" : "R7";
    end else if (c) begin
      m_stk[m_sp] = m_pc;
      m_sp = (m_sp + 1) % 8;
      if (m_depth == 8) m_ovf = 1; else m_depth++;
      m_pc = jump_addr(m_page, t);
      m_flush = 1; tag = "R6";
    end else if (j) begin
      m_pc = jump_addr(m_page, t); m_flush = 1; tag = "R3";
    end else if (l) begin
      m_pc = lowb_addr(m_page, d); m_flush = 1; tag = "R4";
    end else if (a) begin
      m_pc = (m_pc + 1) % 8192;
    end
    if ((r + c + j + l) > 1) tag = "R11";
    if (p) m_page = d % 32;
    @(negedge clk);
    check(tag, pc_o, m_pc);
    check("R10", flush_o, m_flush);
    check("R8", ovf_o, m_ovf);
    adv_i = 0; jmp_i = 0; call_i = 0; ret_i = 0; lo_wr_i = 0; page_wr_i = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_pc = 0; m_page = 0; m_sp = 0; m_depth = 0; m_ovf = 0; m_flush = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", pc_o, 0);
    check("R1", flush_o, 0);
    check("R1", ovf_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 latch is 0: a jump uses page 0
    step(0, 1, 0, 0, 0, 0, 0, 11'h7FF);
    check("R1", pc_o, 2047);
    // R5 same-cycle latch write and low-byte write use old latch
    step(0, 0, 0, 0, 1, 1, 8'h1F, 0);
    check("R5", pc_o, 8'h1F);
    step(0, 0, 0, 0, 1, 0, 8'hFF, 0);
    check("R5", pc_o, 13'h1FFF);
    // R2 wrap from top
    step(1, 0, 0, 0, 0, 0, 0, 0);
    check("R2", pc_o, 0);
    // R8 nine pushes, flag sets on the ninth
    for (int i = 0; i < 9; i++) step(1, 0, 1, 0, 0, 0, 0, 16 * i + 3);
    check("R8", ovf_o, 1);
    // R7/R9 pop past empty
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0, 0, 0, 0);
    // R11 priority corners
    step(1, 1, 1, 1, 1, 0, 5, 9);
    step(1, 1, 1, 0, 1, 0, 5, 9);
    step(1, 1, 0, 0, 1, 1, 5, 9);
    step(1, 0, 0, 0, 1, 0, 5, 9);
    // random mix
    for (int n = 0; n < 2000; n++) begin
      int unsigned k;
      k = $urandom % 16;
      step(k < 10, (k == 10) || ($urandom % 20 == 0), (k == 11) || ($urandom % 20 == 0),
           (k == 12) || ($urandom % 20 == 0), (k == 13) || ($urandom % 20 == 0),
           $urandom % 6 == 0, $urandom % 256, $urandom % 2048);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule